// File: doc/BRIEF.md
# Single-Channel Quadword DMA Engine

This block is one DMA channel that a CPU programs through a small register window. Software loads a source address, a quadword count and an optional tag address, then sets the start bit in the control register. The channel fetches the requested number of 128-bit quadwords from RAM through a dedicated read port and hands each one to a downstream sink that is always ready.

While the transfer runs, the start bit reads back as 1. The channel marks the transfer's progress with three one-cycle events: start, one beat per quadword, and done. On completion the hardware clears the start bit, adds one to a read-only completion counter and pulses an interrupt. Software can therefore poll either the start bit or the counter instead of waiting a fixed number of cycles.

Top module: `dma_chan`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, and start, beat, done, interrupt and read-valid are all low.
- R2: While idle, the CPU can write and read back the control register (offset 0x00, 32 bits), the source address (0x10, 32 bits), the quadword count (0x20, low 16 bits; the upper read bits are 0) and the tag address (0x30, 32 bits). Reads at any other offset return 0.
- R3: The completion counter at offset 0x40 reads 0 after reset and goes up by exactly one per finished transfer. Writes to it have no effect.
- R4: Writing the control register with bit 8 set, while the channel is idle, starts a transfer. Bit 8 reads as 1 from the next cycle until the cycle after done, when it reads 0 again.
- R5: The start event is high for exactly one cycle: the cycle right after the start write.
- R6: In the cycles after the start event, the channel raises read-valid with the current source address. Each granted cycle is a beat: the beat event is high, the beat data equals the read data, the source address goes up by 16 and the count goes down by 1.
- R7: If read-valid is high and grant is low, nothing advances. In the next cycle read-valid is still high with the same address.
- R8: The done event and the interrupt are both high for exactly one cycle: the cycle after the last granted beat. The counter increments and bit 8 clears on the edge that ends that cycle.
- R9: If the count is 0, the done cycle follows the start cycle directly, with no read request and no beat.
- R10: Any register write while a transfer is in progress, including a second start, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | CPU register write strobe |
| reg_wr_addr | input | 8 | CPU write offset |
| reg_wr_data | input | 32 | CPU write data |
| reg_rd_addr | input | 8 | CPU read offset (combinational read) |
| reg_rd_data | output | 32 | CPU read data |
| mem_rd_valid | output | 1 | Quadword read request |
| mem_rd_addr | output | 32 | Byte address of the requested quadword |
| mem_rd_grant | input | 1 | Request accepted; data is valid in the same cycle |
| mem_rd_data | input | 128 | Quadword returned with grant |
| ev_start | output | 1 | Transfer start event |
| ev_beat | output | 1 | One quadword delivered to the sink |
| beat_data | output | 128 | Quadword delivered with the beat event |
| ev_done | output | 1 | Transfer done event |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions take the following for granted about the RAM side. Grant matters only while read-valid is high, and the read data belongs to the address presented in that same cycle. They also take for granted that the CPU drives only the offsets listed above. The bench applies a deterministic pseudo-random grant that also toggles in idle cycles, where it must be ignored. It returns data computed from the requested address and uses only the defined offsets, plus one write to the read-only counter. A behavioural reference model advances on every clock edge and is compared with every output in every cycle. The read offset cycles through the whole register window, so each register value is observed throughout each transfer.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the quadword DMA channel: sequencer phases,
// register offsets and the position of the start bit.
package dma_chan_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ARM    = 2'd1,
        PH_MOVE   = 2'd2,
        PH_FINISH = 2'd3
    } phase_e;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_ADDR  = 8'h10;
    localparam logic [7:0] OFS_COUNT = 8'h20;
    localparam logic [7:0] OFS_TAG   = 8'h30;
    localparam logic [7:0] OFS_DONES = 8'h40;

    localparam int START_BIT = 8;
endpackage

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
// Register block of the DMA channel.
// It holds the control, source address, count, tag and completion-counter
// registers, decodes CPU writes and serves combinational CPU reads.
// Assumptions: the sequencer tells it when a beat is taken and when a transfer
// finishes; all CPU writes are dropped while the sequencer is busy.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int MEM_AW = 32,
    parameter int QWC_W  = 16,
    parameter int CNT_W  = 32,
    parameter int QW_W   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              busy,
    input  logic              beat_take,
    input  logic              finish,
    output logic              start_req,
    output logic [MEM_AW-1:0] madr,
    output logic [QWC_W-1:0]  qwc
);
    localparam logic [MEM_AW-1:0] STRIDE = MEM_AW'(QW_W / 8);

    logic [31:0]       ctrl_q;
    logic [MEM_AW-1:0] madr_q;
    logic [QWC_W-1:0]  qwc_q;
    logic [MEM_AW-1:0] tadr_q;
    logic [CNT_W-1:0]  dones_q;
    logic              wr_ok;

    // Writes are accepted only while the sequencer is idle.
    assign wr_ok     = wr_en && !busy;
    assign start_req = wr_ok && (wr_addr == REG_AW'(OFS_CTRL)) && wr_data[START_BIT];
    assign madr      = madr_q;
    assign qwc       = qwc_q;

    // Control register: CPU load when idle, start bit cleared by hardware on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (finish) begin
            ctrl_q[START_BIT] <= 1'b0;
        end else if (wr_ok && wr_addr == REG_AW'(OFS_CTRL)) begin
            ctrl_q <= wr_data;
        end
    end

    // Source address: advances one quadword per beat, else CPU load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            madr_q <= '0;
        end else if (beat_take) begin
            madr_q <= madr_q + STRIDE;
        end else if (wr_ok && wr_addr == REG_AW'(OFS_ADDR)) begin
            madr_q <= MEM_AW'(wr_data);
        end
    end

    // Quadword count: decrements per beat, else CPU load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qwc_q <= '0;
        end else if (beat_take) begin
            qwc_q <= qwc_q - 1'b1;
        end else if (wr_ok && wr_addr == REG_AW'(OFS_COUNT)) begin
            qwc_q <= wr_data[QWC_W-1:0];
        end
    end

    // Tag address: plain CPU storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tadr_q <= '0;
        end else if (wr_ok && wr_addr == REG_AW'(OFS_TAG)) begin
            tadr_q <= MEM_AW'(wr_data);
        end
    end

    // Completion counter: read-only, one step per finished transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dones_q <= '0;
        end else if (finish) begin
            dones_q <= dones_q + 1'b1;
        end
    end

    // CPU read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_addr == REG_AW'(OFS_CTRL))       rd_data = ctrl_q;
        else if (rd_addr == REG_AW'(OFS_ADDR))  rd_data = 32'(madr_q);
        else if (rd_addr == REG_AW'(OFS_COUNT)) rd_data = 32'(qwc_q);
        else if (rd_addr == REG_AW'(OFS_TAG))   rd_data = 32'(tadr_q);
        else if (rd_addr == REG_AW'(OFS_DONES)) rd_data = 32'(dones_q);
    end

    // The start bit mirrors the sequencer's busy state.
    p_start_bit_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[START_BIT] == busy);

    // A write to the tag while busy leaves it unchanged.
    p_busy_tag_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && busy |=> $stable(tadr_q));

    // The counter moves only on a finish.
    p_dones_only_on_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(dones_q));
endmodule

// File: rtl/dma_chan_engine.sv
`timescale 1ns/1ps
// Transfer sequencer of the DMA channel.
// It walks idle -> arm -> move -> finish, requests one quadword per cycle in
// the move phase and takes a beat on each granted cycle.
// Assumptions: grant returns data in the same cycle; the sink is always ready.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int QWC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [QWC_W-1:0] qwc,
    input  logic             grant,
    output logic             busy,
    output logic             arm,
    output logic             req,
    output logic             beat_take,
    output logic             finish
);
    phase_e ph_q, ph_d;
    logic   qwc_zero, qwc_last;

    assign qwc_zero  = (qwc == '0);
    assign qwc_last  = (qwc == QWC_W'(1));
    assign busy      = (ph_q != PH_IDLE);
    assign arm       = (ph_q == PH_ARM);
    assign req       = (ph_q == PH_MOVE);
    assign beat_take = req && grant;
    assign finish    = (ph_q == PH_FINISH);

    // Next-phase selection.
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:   if (start_req) ph_d = PH_ARM;
            PH_ARM:    ph_d = qwc_zero ? PH_FINISH : PH_MOVE;
            PH_MOVE:   if (grant && qwc_last) ph_d = PH_FINISH;
            PH_FINISH: ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // An empty transfer goes straight from arm to finish.
    p_zero_count_skips_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm && qwc_zero |=> finish);

    // Finish lasts one cycle.
    p_finish_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !finish && !busy);

    // Arm is always followed by a request or a finish.
    p_arm_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !arm && (req || finish));
endmodule

// File: rtl/dma_chan.sv
`timescale 1ns/1ps
// Single-channel quadword DMA: register block plus transfer sequencer.
// It reads the programmed number of quadwords from RAM and passes each one to
// an always-ready sink, then signals completion.
// Assumptions: grant and data belong to the address shown in the same cycle.
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int MEM_AW = 32,
    parameter int QWC_W  = 16,
    parameter int CNT_W  = 32,
    parameter int QW_W   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [REG_AW-1:0] reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    output logic              mem_rd_valid,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic              mem_rd_grant,
    input  logic [QW_W-1:0]   mem_rd_data,
    output logic              ev_start,
    output logic              ev_beat,
    output logic [QW_W-1:0]   beat_data,
    output logic              ev_done,
    output logic              irq
);
    localparam logic [MEM_AW-1:0] STRIDE = MEM_AW'(QW_W / 8);

    logic             busy, start_req, beat_take, finish, arm, req;
    logic [QWC_W-1:0] qwc;

    dma_chan_regs #(
        .REG_AW(REG_AW), .MEM_AW(MEM_AW), .QWC_W(QWC_W), .CNT_W(CNT_W), .QW_W(QW_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .busy(busy), .beat_take(beat_take), .finish(finish),
        .start_req(start_req), .madr(mem_rd_addr), .qwc(qwc)
    );

    dma_chan_engine #(.QWC_W(QWC_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .qwc(qwc), .grant(mem_rd_grant),
        .busy(busy), .arm(arm), .req(req), .beat_take(beat_take), .finish(finish)
    );

    // Event and sink outputs.
    assign mem_rd_valid = req;
    assign ev_start     = arm;
    assign ev_beat      = beat_take;
    assign beat_data    = mem_rd_data;
    assign ev_done      = finish;
    assign irq          = finish;

    // Events never overlap.
    p_events_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_beat, ev_done}));

    // Each beat advances the address by one quadword.
    p_beat_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_beat && !$past(!rst_n) |=> mem_rd_addr == $past(mem_rd_addr) + STRIDE);

    // A denied request is repeated unchanged.
    p_retry_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_grant |=> mem_rd_valid && $stable(mem_rd_addr));

    // The interrupt is a one-cycle pulse.
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // A start written while busy raises no new start event.
    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && mem_rd_valid |=> !ev_start);
endmodule

// File: tb/test_dma_chan.sv
`timescale 1ns/1ps
// Bench for dma_chan: a behavioural reference model, updated on every rising
// edge, is compared with every output shortly after each falling edge.
module test_dma_chan;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [7:0]   reg_wr_addr = '0;
    logic [31:0]  reg_wr_data = '0;
    logic [7:0]   reg_rd_addr = '0;
    logic [31:0]  reg_rd_data;
    logic         mem_rd_valid;
    logic [31:0]  mem_rd_addr;
    logic         mem_rd_grant = 1'b1;
    logic [127:0] mem_rd_data;
    logic         ev_start, ev_beat, ev_done, irq;
    logic [127:0] beat_data;

    int checks = 0;
    int errors = 0;
    bit checking = 1'b0;
    bit finished = 1'b0;
    bit grant_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int rd_sel = 0;

    always #2.5 clk = ~clk;

    dma_chan i_dma_chan (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_grant(mem_rd_grant), .mem_rd_data(mem_rd_data),
        .ev_start(ev_start), .ev_beat(ev_beat), .beat_data(beat_data),
        .ev_done(ev_done), .irq(irq)
    );

    function automatic logic [127:0] ram_word(input logic [31:0] a);
        return {a ^ 32'h1111_1111, a, ~a, a + 32'd7};
    endfunction

    // RAM model: data derived from the requested address.
    assign mem_rd_data = ram_word(mem_rd_addr);

    // Reference model state.
    logic [31:0] m_ctrl, m_madr, m_tadr, m_cnt;
    logic [15:0] m_qwc;
    int          m_ph;   // 0 idle, 1 start cycle, 2 fetching, 3 done cycle

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_madr = '0; m_tadr = '0; m_cnt = '0; m_qwc = '0; m_ph = 0;
        end else begin
            case (m_ph)
                0: if (reg_wr_en) begin
                    case (reg_wr_addr)
                        8'h00: begin m_ctrl = reg_wr_data; if (reg_wr_data[8]) m_ph = 1; end
                        8'h10: m_madr = reg_wr_data;
                        8'h20: m_qwc = reg_wr_data[15:0];
                        8'h30: m_tadr = reg_wr_data;
                        default: ;
                    endcase
                end
                1: m_ph = (m_qwc == 0) ? 3 : 2;
                2: if (mem_rd_grant) begin
                    m_madr = m_madr + 32'd16;
                    m_qwc  = m_qwc - 16'd1;
                    if (m_qwc == 0) m_ph = 3;
                end
                default: begin m_ctrl[8] = 1'b0; m_cnt = m_cnt + 1; m_ph = 0; end
            endcase
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h10: return m_madr;
            8'h20: return {16'h0, m_qwc};
            8'h30: return m_tadr;
            8'h40: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        #1;
        if (checking) begin
            chk("R5", "ev_start", ev_start, m_ph == 1);
            chk("R7", "mem_rd_valid", mem_rd_valid, m_ph == 2);
            if (m_ph == 2) chk("R7", "mem_rd_addr", mem_rd_addr, m_madr);
            chk("R6", "ev_beat", ev_beat, (m_ph == 2) && mem_rd_grant);
            if (m_ph == 2 && mem_rd_grant) chk("R6", "beat_data", beat_data, ram_word(m_madr));
            chk("R8", "ev_done", ev_done, m_ph == 3);
            chk("R8", "irq", irq, m_ph == 3);
            if (reg_rd_addr == 8'h40)      chk("R3", "done counter", reg_rd_data, exp_read(reg_rd_addr));
            else if (reg_rd_addr == 8'h00) chk("R4", "control", reg_rd_data, exp_read(reg_rd_addr));
            else                           chk("R2", "register read", reg_rd_data, exp_read(reg_rd_addr));
        end
    end

    // Read-offset sweep over the window, including the unused offset 0x50.
    always @(negedge clk) begin
        rd_sel = (rd_sel + 1) % 6;
        reg_rd_addr = 8'(rd_sel * 16);
    end

    // Grant source: always 1, or pseudo-random (toggles even when idle).
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (grant_rand) mem_rd_grant = lfsr[0] | lfsr[3];
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        checking = 1'b1;
        @(negedge clk);
        #2;
        // R1: reset state of events and request.
        chk("R1", "events after reset", {ev_start, ev_beat, ev_done, irq, mem_rd_valid}, 5'b0);
        idle(8);   // R1/R2: sweep reads every register at its reset value

        // R2 R4 R6: three quadwords with grant always high.
        wr(8'h10, 32'h0000_1000);
        wr(8'h20, 32'hFFFF_0003);   // only the low 16 bits are kept
        wr(8'h30, 32'h0000_0055);
        wr(8'h00, 32'h0000_0104);
        idle(12);

        // R7 R10: five quadwords under random grant; writes while busy are dropped.
        grant_rand = 1'b1;
        wr(8'h10, 32'h0000_2000);
        wr(8'h20, 32'h0000_0005);
        wr(8'h00, 32'h0000_0100);
        wr(8'h10, 32'hDEAD_0000);
        wr(8'h00, 32'h0000_0101);
        wr(8'h30, 32'h1234_5678);
        idle(30);

        // R9: zero-count transfer completes with no beats.
        wr(8'h20, 32'h0000_0000);
        wr(8'h00, 32'h0000_0100);
        idle(8);

        // R3: the counter ignores CPU writes.
        wr(8'h40, 32'h0000_00FF);
        idle(8);

        // R7: one quadword held back by a denied grant for several cycles.
        grant_rand = 1'b0;
        mem_rd_grant = 1'b0;
        wr(8'h10, 32'h0000_3000);
        wr(8'h20, 32'h0000_0001);
        wr(8'h00, 32'h0000_0100);
        idle(5);
        mem_rd_grant = 1'b1;
        idle(10);

        // R8: back-to-back transfers step the counter twice more.
        wr(8'h20, 32'h0000_0002);
        wr(8'h00, 32'h0000_0100);
        idle(8);
        wr(8'h00, 32'h0000_0100);
        idle(12);

        checking = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule